// File: doc/BRIEF.md
# Word-Serial Montgomery Reduction Engine

This block takes a double-length value T, held as 2N words of 16 bits, and reduces it modulo an odd N-word modulus p by the Montgomery method. The result is T·R⁻¹ mod p with R = 2^(16N), and no division is performed anywhere. The block is meant to follow a product-scanning multiplier inside a modular-multiplication path whose operands are kept in Montgomery form. Conversion into and out of that form is left to the surrounding logic.

Operands arrive over one word-wide write port. The port carries three banks: the words of T, the words of p, and the single-word constant p' = −p⁻¹ mod 2^16. A start pulse launches the reduction. The engine then walks the 2N result columns with one multiply-accumulate per cycle into a three-word accumulator. In each low column it forms a quotient word from the accumulator's low word and p', and adding that quotient times the modulus clears the low word. In each high column it folds in the upper words of T and emits one result word. A final conditional subtraction of p brings the output into [0, p). A one-cycle done pulse marks the moment the result register takes the new value.

Top module: `mred_engine`

## Requirements
- R1: After reset, busy and done are 0 and result is all zeros.
- R2: For odd p, p' = −p⁻¹ mod 2^16 and T < p·R, the result equals T·R⁻¹ mod p with R = 2^(16·NWORDS).
- R3: The result is always below p. When the column pass leaves a value of p or more, including one with a nonzero carry word, p is subtracted once.
- R4: T = 0 gives a result of 0.
- R5: done rises exactly NWORDS²+5·NWORDS+1 clock edges after the edge that accepts start, stays high for one cycle, and coincides with busy = 0. busy is 1 from the edge after start until done.
- R6: A write on the load port (ld_en = 1) stores ld_data only while the engine is idle. Bank code 0 selects T word ld_idx (word 0 least significant, 0..2·NWORDS−1). Code 1 selects modulus word ld_idx (0..NWORDS−1). Code 2 selects p'. Writes made while busy are dropped.
- R7: A start pulse while busy has no effect on the running reduction or its timing.
- R8: result changes only on the edge that raises done, and holds its value until the next reduction completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Operand word write strobe |
| ld_bank | input | 2 | Bank code: 0 = T, 1 = modulus, 2 = p' |
| ld_idx | input | $clog2(2·NWORDS) | Word index within the bank |
| ld_data | input | WORD_W | Word to store |
| start | input | 1 | Launches a reduction when idle |
| busy | output | 1 | Reduction in progress |
| done | output | 1 | One-cycle pulse: result updated |
| result | output | NWORDS·WORD_W | T·R⁻¹ mod p, word 0 in the low bits |

## Verification
With the default four words, every result is due exactly 37 edges after the edge that sampled start. The scoreboard entry records the cycle count at start, and the monitor compares that count with the one seen when done is sampled at the following falling edge. The monitor samples every output on falling edges only. Each expected value therefore refers to state settled by the preceding rising edge: busy one edge after start, result and done on the completing edge, and the held result several cycles later. A disturbed run writes a modulus word and pulses start mid-run. It must still finish on the same cycle with the undisturbed value, and a rerun without reloading must reproduce that value.

// File: rtl/mred_pkg.sv
// Shared types for the Montgomery reduction engine.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package mred_pkg;

    // Operation requested from the three-word accumulator each cycle
    typedef enum logic [1:0] {
        ACC_HOLD = 2'd0,
        ACC_MAC  = 2'd1,
        ACC_ADDW = 2'd2,
        ACC_SHR  = 2'd3
    } acc_op_e;

    // Sequencer states of the column walk
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PROD  = 3'd1,
        ST_ADDT  = 3'd2,
        ST_QUOT  = 3'd3,
        ST_QADD  = 3'd4,
        ST_SHIFT = 3'd5,
        ST_FIN   = 3'd6
    } st_e;

    // Load port bank codes
    localparam logic [1:0] BANK_T    = 2'd0;
    localparam logic [1:0] BANK_MOD  = 2'd1;
    localparam logic [1:0] BANK_NINV = 2'd2;

endpackage

// File: rtl/mred_acc.sv
// Three-word column accumulator.
// Each cycle it either adds a W x W product, adds one word, shifts right by
// one word, or holds. The top word only gathers carries.
// Assumes: the caller never lets the true sum reach 2^(3W).
module mred_acc
    import mred_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  acc_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] x,
    output logic [W-1:0] lo
);
    localparam int AW = 3 * W;

    logic [AW-1:0]  acc;
    logic [AW:0]    sum;
    logic [2*W-1:0] prod;

    // Full double-width product of the two operand words
    assign prod = {{W{1'b0}}, a} * {{W{1'b0}}, b};

    // Next accumulator value for the requested operation
    always_comb begin
        unique case (op)
            ACC_MAC:  sum = {1'b0, acc} + {{(W + 1){1'b0}}, prod};
            ACC_ADDW: sum = {1'b0, acc} + {{(2 * W + 1){1'b0}}, x};
            ACC_SHR:  sum = {{(W + 1){1'b0}}, acc[AW-1:W]};
            default:  sum = {1'b0, acc};
        endcase
    end

    // Accumulator register with clear at the start of a reduction
    always_ff @(posedge clk) begin
        if (!rst_n)   acc <= '0;
        else if (clr) acc <= '0;
        else          acc <= sum[AW-1:0];
    end

    assign lo = acc[W-1:0];

    // R2: no column sum may wrap the three-word accumulator
    p_acc_no_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op != ACC_HOLD) |-> !sum[AW]);

endmodule

// File: rtl/mred_store.sv
// Operand register banks: 2N words of T, N words of the modulus, one word p'.
// Written one word at a time; writes are accepted only when wr_en is high.
// Assumes: the caller masks wr_en while a reduction runs.
module mred_store
    import mred_pkg::*;
#(
    parameter int W     = 16,
    parameter int N     = 4,
    parameter int IDX_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [1:0]            bank,
    input  logic [IDX_W-1:0]      idx,
    input  logic [W-1:0]          data,
    output logic [2*N-1:0][W-1:0] t_q,
    output logic [N-1:0][W-1:0]   mod_q,
    output logic [W-1:0]          ninv_q
);
    localparam int NI = (N > 1) ? $clog2(N) : 1;

    // Store the incoming word in the bank and slot it addresses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q    <= '0;
            mod_q  <= '0;
            ninv_q <= '0;
        end else if (wr_en) begin
            if (bank == BANK_T && 32'(idx) < 2 * N)
                t_q[idx] <= data;
            else if (bank == BANK_MOD && 32'(idx) < N)
                mod_q[NI'(idx)] <= data;
            else if (bank == BANK_NINV)
                ninv_q <= data;
        end
    end

endmodule

// File: rtl/mred_final_sub.sv
// Final correction: given the N-word column result plus its carry word,
// returns value - mod if that is non-negative, otherwise the value itself.
// Assumes: value < 2*mod, so one subtraction always suffices.
module mred_final_sub #(
    parameter int W = 16,
    parameter int N = 4
) (
    input  logic [N-1:0][W-1:0] val,
    input  logic [W-1:0]        top,
    input  logic [N-1:0][W-1:0] mod,
    output logic [N-1:0][W-1:0] res
);
    logic [N:0]          brw;
    logic [N-1:0][W-1:0] diff;
    logic                under;

    assign brw[0] = 1'b0;

    // Word-by-word borrow chain of val - mod
    for (genvar k = 0; k < N; k++) begin : g_word
        assign {brw[k+1], diff[k]} = {1'b0, val[k]} - {1'b0, mod[k]}
                                     - {{W{1'b0}}, brw[k]};
    end

    // Value is below the modulus only if the borrow survives the carry word
    assign under = (top == '0) && brw[N];
    assign res   = under ? val : diff;

endmodule

// File: rtl/mred_engine.sv
// Montgomery reduction engine, product-scanning order.
// Reduces a 2N-word T to T * 2^(-W*N) mod p, one multiply-accumulate per
// cycle. Low columns create quotient words q[i] = lo * p' mod 2^W; high
// columns fold in the upper words of T and emit result words; a final
// subtraction brings the value into [0, p).
// Assumes: p odd, p' = -p^-1 mod 2^W, T < p * 2^(W*N), N >= 2.
module mred_engine
    import mred_pkg::*;
#(
    parameter int  NWORDS = 4,
    parameter int  WORD_W = 16,
    localparam int IDX_W  = $clog2(2 * NWORDS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ld_en,
    input  logic [1:0]               ld_bank,
    input  logic [IDX_W-1:0]         ld_idx,
    input  logic [WORD_W-1:0]        ld_data,
    input  logic                     start,
    output logic                     busy,
    output logic                     done,
    output logic [NWORDS*WORD_W-1:0] result
);
    localparam int N  = NWORDS;
    localparam int W  = WORD_W;
    localparam int NI = (N > 1) ? $clog2(N) : 1;
    localparam logic [IDX_W-1:0] N_C    = IDX_W'(N);
    localparam logic [IDX_W-1:0] LAST_C = IDX_W'(2 * N - 1);

    st_e                   st;
    logic [IDX_W-1:0]      col, jdx, jend, nxt;
    logic [N-1:0][W-1:0]   q_mem, s_mem, res_q, sub_res;
    logic [2*N-1:0][W-1:0] t_q;
    logic [N-1:0][W-1:0]   mod_q;
    logic [W-1:0]          ninv_q, acc_lo, qword, acc_a, acc_b, acc_x;
    logic                  col_low, acc_clr, done_q;
    acc_op_e               acc_op;

    assign busy    = (st != ST_IDLE);
    assign done    = done_q;
    assign result  = res_q;
    assign col_low = (col < N_C);
    assign nxt     = col + 1'b1;
    assign qword   = acc_lo * ninv_q;

    mred_store #(.W(W), .N(N), .IDX_W(IDX_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (ld_en && !busy),
        .bank  (ld_bank),
        .idx   (ld_idx),
        .data  (ld_data),
        .t_q   (t_q),
        .mod_q (mod_q),
        .ninv_q(ninv_q)
    );

    mred_acc #(.W(W)) u_acc (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (acc_clr),
        .op   (acc_op),
        .a    (acc_a),
        .b    (acc_b),
        .x    (acc_x),
        .lo   (acc_lo)
    );

    mred_final_sub #(.W(W), .N(N)) u_fsub (
        .val(s_mem),
        .top(acc_lo),
        .mod(mod_q),
        .res(sub_res)
    );

    // Select accumulator operation and operands from the sequencer state
    always_comb begin
        acc_clr = (st == ST_IDLE) && start;
        acc_op  = ACC_HOLD;
        acc_a   = q_mem[NI'(jdx)];
        acc_b   = mod_q[NI'(col - jdx)];
        acc_x   = t_q[col];
        unique case (st)
            ST_PROD:  acc_op = ACC_MAC;
            ST_ADDT:  acc_op = ACC_ADDW;
            ST_QADD: begin
                acc_op = ACC_MAC;
                acc_a  = q_mem[NI'(col)];
                acc_b  = mod_q[0];
            end
            ST_SHIFT: acc_op = ACC_SHR;
            default:  acc_op = ACC_HOLD;
        endcase
    end

    // Column sequencer: walks products, quotient steps and result emission
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            col    <= '0;
            jdx    <= '0;
            jend   <= '0;
            q_mem  <= '0;
            s_mem  <= '0;
            res_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        col <= '0;
                        st  <= ST_ADDT;
                    end
                end
                ST_PROD: begin
                    jdx <= jdx + 1'b1;
                    if (jdx + 1'b1 == jend) st <= ST_ADDT;
                end
                ST_ADDT: st <= col_low ? ST_QUOT : ST_SHIFT;
                ST_QUOT: begin
                    q_mem[NI'(col)] <= qword;
                    st              <= ST_QADD;
                end
                ST_QADD: st <= ST_SHIFT;
                ST_SHIFT: begin
                    if (!col_low) s_mem[NI'(col - N_C)] <= acc_lo;
                    if (col == LAST_C) begin
                        st <= ST_FIN;
                    end else begin
                        col <= nxt;
                        if (nxt < N_C) begin
                            jdx  <= '0;
                            jend <= nxt;
                            st   <= ST_PROD;
                        end else begin
                            jdx  <= nxt - N_C + 1'b1;
                            jend <= N_C;
                            st   <= (nxt == LAST_C) ? ST_ADDT : ST_PROD;
                        end
                    end
                end
                ST_FIN: begin
                    res_q  <= sub_res;
                    done_q <= 1'b1;
                    st     <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R2: the quotient step must clear the low accumulator word
    p_low_cleared_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SHIFT && col_low) |-> (acc_lo == '0));

    // R3: every delivered result lies below the modulus
    p_below_mod_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (res_q < mod_q));

    // R5: done is a single-cycle pulse
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: the engine is idle whenever done is shown
    p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7: a running reduction keeps going regardless of start
    p_run_continues_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && st != ST_FIN) |=> busy);

    // R8: result moves only together with done
    p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

endmodule

// File: tb/tb_mred_engine.sv
// Scoreboard bench: the driver pushes expected results, the monitor pops
// and compares them when done is seen.
module tb_mred_engine;
    localparam int NW    = 4;
    localparam int WW    = 16;
    localparam int BITS  = NW * WW;
    localparam int IDXW  = $clog2(2 * NW);
    localparam int LAT   = NW * NW + 5 * NW + 1;

    typedef struct {
        logic [BITS-1:0] res;
        logic [BITS-1:0] modv;
        int              cyc0;
        string           tag;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ld_en = 1'b0;
    logic [1:0]      ld_bank = '0;
    logic [IDXW-1:0] ld_idx = '0;
    logic [WW-1:0]   ld_data = '0;
    logic            start = 1'b0;
    logic            busy, done;
    logic [BITS-1:0] result;

    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;
    exp_t sb[$];
    logic [BITS-1:0] last_res;

    mred_engine #(.NWORDS(NW), .WORD_W(WW)) dut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_bank(ld_bank),
        .ld_idx(ld_idx), .ld_data(ld_data), .start(start),
        .busy(busy), .done(done), .result(result)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req,
                         input logic [BITS-1:0] act, input logic [BITS-1:0] exv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exv);
        end
    endtask

    // Independent model: bit-serial halving modulo p, BITS times
    function automatic logic [BITS-1:0] ref_red(input logic [2*BITS-1:0] t,
                                                input logic [BITS-1:0] p);
        logic [BITS+1:0] x;
        x = (BITS+2)'(t % {{BITS{1'b0}}, p});
        for (int k = 0; k < BITS; k++) begin
            if (x[0]) x = x + {2'b00, p};
            x = x >> 1;
        end
        return x[BITS-1:0];
    endfunction

    // Newton iteration for -p^-1 mod 2^16
    function automatic logic [WW-1:0] neg_inv(input logic [WW-1:0] p0);
        logic [WW-1:0] v;
        v = p0;
        for (int k = 0; k < 4; k++) v = v * (16'd2 - p0 * v);
        return -v;
    endfunction

    task automatic put_word(input logic [1:0] bank, input int idx,
                            input logic [WW-1:0] data);
        @(negedge clk);
        ld_en = 1'b1; ld_bank = bank; ld_idx = IDXW'(idx); ld_data = data;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic pulse_start(input logic [BITS-1:0] expv,
                               input logic [BITS-1:0] p, input string tag);
        exp_t e;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        e.res = expv; e.modv = p; e.cyc0 = cyc; e.tag = tag;
        sb.push_back(e);
        check(busy == 1'b1, "R5 busy after start", BITS'(busy), 1);
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    // Load operands (R6 codes 0/1/2), run, and optionally disturb (R6, R7)
    task automatic run_case(input logic [2*BITS-1:0] t, input logic [BITS-1:0] p,
                            input string tag, input bit disturb);
        logic [BITS-1:0] expv;
        for (int k = 0; k < 2 * NW; k++) put_word(2'd0, k, t[k*WW +: WW]);
        for (int k = 0; k < NW; k++)     put_word(2'd1, k, p[k*WW +: WW]);
        put_word(2'd2, 0, neg_inv(p[WW-1:0]));
        expv = ref_red(t, p);
        pulse_start(expv, p, tag);
        if (disturb) begin
            repeat (4) @(negedge clk);
            ld_en = 1'b1; ld_bank = 2'd1; ld_idx = '0; ld_data = ~p[WW-1:0];
            start = 1'b1;
            @(negedge clk);
            ld_en = 1'b0; start = 1'b0;
        end
        wait_done();
        last_res = expv;
        if (disturb) begin
            pulse_start(expv, p, "R6 rerun after busy write");
            wait_done();
        end
    endtask

    // Monitor: pop expected item on each done and compare
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R5 unexpected done", BITS'(1), 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(result == e.res, e.tag, result, e.res);
                check(result < e.modv, "R3 below modulus", result, e.modv);
                check(cyc - e.cyc0 == LAT, "R5 latency (R7 if disturbed)",
                      BITS'(cyc - e.cyc0), BITS'(LAT));
                check(busy == 1'b0, "R5 busy low at done", BITS'(busy), 0);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [BITS-1:0] mods[5];
        logic [BITS-1:0] p, hi, lo;
        mods[0] = 64'hFFFF_FFFF_FFFF_FFC5;
        mods[1] = 64'h8000_0000_0000_0001;
        mods[2] = {$urandom, $urandom} | 64'h8000_0000_0000_0001;
        mods[3] = 64'd3;
        mods[4] = 64'h0000_0001_0000_0F1B;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0, "R1 busy reset", BITS'(busy), 0);
        check(done == 1'b0, "R1 done reset", BITS'(done), 0);
        check(result == '0, "R1 result reset", result, 0);

        for (int m = 0; m < 5; m++) begin
            p = mods[m];
            run_case('0, p, "R4 zero input", 1'b0);
            run_case({p - 1'b1, {BITS{1'b1}}}, p, "R2 largest T", 1'b0);
            for (int r = 0; r < 5; r++) begin
                hi = {$urandom, $urandom} % p;
                lo = {$urandom, $urandom};
                run_case({hi, lo}, p, "R2 random T", 1'b0);
            end
        end

        // R6 and R7: write and start pulse while busy are ignored
        p  = mods[0];
        hi = {$urandom, $urandom} % p;
        run_case({hi, 64'h1234_5678_9ABC_DEF0}, p, "R6 R7 disturbed run", 1'b1);

        // R8: result holds after done
        repeat (5) @(negedge clk);
        check(result == last_res, "R8 result held", result, last_res);
        check(done == 1'b0, "R5 done single pulse", BITS'(done), 0);

        repeat (2) @(negedge clk);
        check(sb.size() == 0, "R5 all results delivered", BITS'(sb.size()), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule